// File: doc/BRIEF.md
# Accumulator-Machine Register Space

This block holds the architectural registers of a 16-bit accumulator CPU. The registers sit in one 64-entry index space. Indices 0 to 31 are general registers. The accumulator, memory pointer, stack pointer and program counter sit at the top four indices. Indices 32 to 59 have no storage behind them.

Two combinational read ports serve operand fetch. One write port applies a write mode chosen per cycle: full word, upper byte, top nibble, sign- or zero-extended immediates, or increment and decrement. An access-class input tells the block which instruction group issued the write. A write whose index lies outside that group's permitted range is dropped, and a one-cycle illegal strobe is raised.

The four special registers are also driven on dedicated outputs, so fetch and address logic can use them without spending a read port.

Top module: `regf_core`

## Requirements
- R1: Asynchronous active-low reset clears every register to zero and drives the illegal strobe low.
- R2: Indices 0–31 address general registers. Index 60 is the accumulator (`acc_o`), 61 the memory pointer (`mptr_o`), 62 the stack pointer (`sp_o`) and 63 the program counter (`pc_o`). A legal write to any of these is seen on the read ports and on the matching dedicated output.
- R3: Reads of indices 32–59 return zero. Writes to them change nothing and, under the unrestricted class, raise no strobe.
- R4: A read port addressing index 63 returns the program counter plus 4, modulo 2^16. `pc_o` shows the stored value unchanged.
- R5: Mode 0 (word) stores all 16 data bits.
- R6: Mode 1 (high byte) stores data[7:0] into bits 15:8 and keeps bits 7:0.
- R7: Mode 2 (top nibble) stores data[3:0] into bits 15:12 and keeps bits 11:0.
- R8: Mode 3 stores data[7:0] sign-extended. Mode 4 stores data[11:0] sign-extended. Mode 5 stores data[11:0] zero-extended.
- R9: Mode 6 adds one to the target and mode 7 subtracts one, both wrapping at 16 bits. The data input is not used.
- R10: The access classes are 0 = any index, 1 = load/store (indices 0–15 only), 2 = stack/step (0–31 only) and 3 = special (60–63 only). A write outside its class's range is discarded. `illegal_o` is then high for exactly the cycle after that write.
- R11: A read of the index being written in the same cycle returns the old value. The new value appears from the next cycle.
- R12: With write enable low, `illegal_o` stays low whatever the class and index inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 6 | Read port A index |
| rd_a_data_o | output | 16 | Read port A data |
| rd_b_idx_i | input | 6 | Read port B index |
| rd_b_data_o | output | 16 | Read port B data |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 6 | Write index |
| wr_mode_i | input | 3 | Write mode (R5–R9 encodings) |
| wr_class_i | input | 2 | Access class of issuing instruction (R10 encoding) |
| wr_data_i | input | 16 | Write data / immediate |
| illegal_o | output | 1 | One-cycle strobe on a class violation |
| acc_o | output | 16 | Accumulator |
| mptr_o | output | 16 | Memory pointer |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 16 | Program counter (stored value) |

## Verification
A read and a write can meet on the same index in one cycle, for example when an instruction reads an operand that the previous instruction is still writing back. The bench provokes this by setting the read index equal to the write index before the clock edge. It expects the old contents just before the edge and the merged result just after.

The other collision is a partial write or a step. There the merge reads the current contents in the same cycle it writes them back. The high-byte, top-nibble and increment/decrement vectors judge this by checking that the untouched field survives and that the result wraps at 16 bits.

// File: rtl/regf_pkg.sv
package regf_pkg;
  typedef enum logic [2:0] {
    WM_WORD    = 3'd0,
    WM_HI_BYTE = 3'd1,
    WM_TOP_NIB = 3'd2,
    WM_SEXT8   = 3'd3,
    WM_SEXT12  = 3'd4,
    WM_ZEXT12  = 3'd5,
    WM_INC     = 3'd6,
    WM_DEC     = 3'd7
  } wr_mode_e;

  typedef enum logic [1:0] {
    AC_ANY     = 2'd0,
    AC_LDST    = 2'd1,
    AC_STACK   = 2'd2,
    AC_SPECIAL = 2'd3
  } acc_class_e;

  localparam int unsigned NUM_SPECIAL = 4;
endpackage

// File: rtl/regf_class_chk.sv
module regf_class_chk
  import regf_pkg::*;
#(
  parameter int unsigned AW           = 6,
  parameter int unsigned LDST_COUNT   = 16,
  parameter int unsigned GPR_COUNT    = 32,
  parameter int unsigned SPECIAL_BASE = 60
) (
  input  logic [AW-1:0] idx_i,
  input  acc_class_e    class_i,
  output logic          legal_o
);
  logic [31:0] idx_w;
  assign idx_w = 32'(idx_i);

  always_comb begin
    unique case (class_i)
      AC_ANY:     legal_o = 1'b1;
      AC_LDST:    legal_o = idx_w < LDST_COUNT;
      AC_STACK:   legal_o = idx_w < GPR_COUNT;
      AC_SPECIAL: legal_o = idx_w >= SPECIAL_BASE;
      default:    legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/regf_wr_merge.sv
module regf_wr_merge
  import regf_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] data_i,
  input  wr_mode_e      mode_i,
  output logic [DW-1:0] new_o
);
  always_comb begin
    unique case (mode_i)
      WM_WORD:    new_o = data_i;
      WM_HI_BYTE: new_o = {data_i[7:0], old_i[DW-9:0]};
      WM_TOP_NIB: new_o = {data_i[3:0], old_i[DW-5:0]};
      WM_SEXT8:   new_o = {{(DW-8){data_i[7]}}, data_i[7:0]};
      WM_SEXT12:  new_o = {{(DW-12){data_i[11]}}, data_i[11:0]};
      WM_ZEXT12:  new_o = {{(DW-12){1'b0}}, data_i[11:0]};
      WM_INC:     new_o = old_i + DW'(1);
      WM_DEC:     new_o = old_i - DW'(1);
      default:    new_o = old_i;
    endcase
  end
endmodule

// File: rtl/regf_read_mux.sv
module regf_read_mux
  import regf_pkg::*;
#(
  parameter int unsigned DW           = 16,
  parameter int unsigned AW           = 6,
  parameter int unsigned GPR_COUNT    = 32,
  parameter int unsigned SPECIAL_BASE = 60,
  parameter int unsigned PC_OFFSET    = 4
) (
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] gpr_i  [GPR_COUNT],
  input  logic [DW-1:0] spec_i [NUM_SPECIAL],
  output logic [DW-1:0] data_o
);
  localparam int unsigned GW = $clog2(GPR_COUNT);

  logic [31:0]   idx_w;
  logic [AW-1:0] spec_off;
  assign idx_w    = 32'(idx_i);
  assign spec_off = idx_i - AW'(SPECIAL_BASE);

  always_comb begin
    data_o = '0;
    if (idx_w < GPR_COUNT) begin
      data_o = gpr_i[idx_i[GW-1:0]];
    end else if (idx_w >= SPECIAL_BASE) begin
      data_o = spec_i[spec_off[1:0]];
      // program counter reads as the return address
      if (spec_off[1:0] == 2'd3) data_o = spec_i[3] + DW'(PC_OFFSET);
    end
  end
endmodule

// File: rtl/regf_core.sv
module regf_core
  import regf_pkg::*;
#(
  parameter int unsigned DW             = 16,
  parameter int unsigned GPR_COUNT      = 32,
  parameter int unsigned NUM_IDX        = 64,
  parameter int unsigned LDST_COUNT     = 16,
  parameter int unsigned PC_READ_OFFSET = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [$clog2(NUM_IDX)-1:0] rd_a_idx_i,
  output logic [DW-1:0]              rd_a_data_o,
  input  logic [$clog2(NUM_IDX)-1:0] rd_b_idx_i,
  output logic [DW-1:0]              rd_b_data_o,
  input  logic                       wr_en_i,
  input  logic [$clog2(NUM_IDX)-1:0] wr_idx_i,
  input  logic [2:0]                 wr_mode_i,
  input  logic [1:0]                 wr_class_i,
  input  logic [DW-1:0]              wr_data_i,
  output logic                       illegal_o,
  output logic [DW-1:0]              acc_o,
  output logic [DW-1:0]              mptr_o,
  output logic [DW-1:0]              sp_o,
  output logic [DW-1:0]              pc_o
);
  localparam int unsigned AW           = $clog2(NUM_IDX);
  localparam int unsigned SPECIAL_BASE = NUM_IDX - NUM_SPECIAL;

  logic [DW-1:0] gpr_q  [GPR_COUNT];
  logic [DW-1:0] spec_q [NUM_SPECIAL];
  logic [DW-1:0] old_val, new_val;
  logic          legal, wr_fire, illegal_q;

  regf_class_chk #(
    .AW(AW), .LDST_COUNT(LDST_COUNT), .GPR_COUNT(GPR_COUNT), .SPECIAL_BASE(SPECIAL_BASE)
  ) u_class (
    .idx_i(wr_idx_i), .class_i(acc_class_e'(wr_class_i)), .legal_o(legal)
  );

  assign wr_fire = wr_en_i & legal;

  // old contents of the write target, raw PC (no offset)
  regf_read_mux #(
    .DW(DW), .AW(AW), .GPR_COUNT(GPR_COUNT), .SPECIAL_BASE(SPECIAL_BASE), .PC_OFFSET(0)
  ) u_old (
    .idx_i(wr_idx_i), .gpr_i(gpr_q), .spec_i(spec_q), .data_o(old_val)
  );

  regf_wr_merge #(.DW(DW)) u_merge (
    .old_i(old_val), .data_i(wr_data_i), .mode_i(wr_mode_e'(wr_mode_i)), .new_o(new_val)
  );

  for (genvar g = 0; g < GPR_COUNT; g++) begin : g_gpr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 gpr_q[g] <= '0;
      else if (wr_fire && wr_idx_i == AW'(g))      gpr_q[g] <= new_val;
    end
  end

  for (genvar s = 0; s < NUM_SPECIAL; s++) begin : g_spec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          spec_q[s] <= '0;
      else if (wr_fire && wr_idx_i == AW'(SPECIAL_BASE + s)) spec_q[s] <= new_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= wr_en_i & ~legal;
  end

  for (genvar p = 0; p < 2; p++) begin : g_rport
    logic [AW-1:0] idx;
    logic [DW-1:0] data;
    assign idx = (p == 0) ? rd_a_idx_i : rd_b_idx_i;
    regf_read_mux #(
      .DW(DW), .AW(AW), .GPR_COUNT(GPR_COUNT), .SPECIAL_BASE(SPECIAL_BASE),
      .PC_OFFSET(PC_READ_OFFSET)
    ) u_rd (
      .idx_i(idx), .gpr_i(gpr_q), .spec_i(spec_q), .data_o(data)
    );
  end

  assign rd_a_data_o = g_rport[0].data;
  assign rd_b_data_o = g_rport[1].data;
  assign illegal_o   = illegal_q;
  assign acc_o       = spec_q[0];
  assign mptr_o      = spec_q[1];
  assign sp_o        = spec_q[2];
  assign pc_o        = spec_q[3];
endmodule

// File: rtl/regf_core_chk.sv
module regf_core_chk #(
  parameter int unsigned DW             = 16,
  parameter int unsigned GPR_COUNT      = 32,
  parameter int unsigned NUM_IDX        = 64,
  parameter int unsigned LDST_COUNT     = 16,
  parameter int unsigned PC_READ_OFFSET = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic [$clog2(NUM_IDX)-1:0] wr_idx_i,
  input logic [2:0]                 wr_mode_i,
  input logic [1:0]                 wr_class_i,
  input logic [$clog2(NUM_IDX)-1:0] rd_a_idx_i,
  input logic [DW-1:0]              rd_a_data_o,
  input logic                       illegal_o,
  input logic [DW-1:0]              acc_o,
  input logic [DW-1:0]              mptr_o,
  input logic [DW-1:0]              sp_o,
  input logic [DW-1:0]              pc_o
);
  localparam int unsigned SB = NUM_IDX - 4;

  logic rd_unmapped, wr_unmapped;
  assign rd_unmapped = 32'(rd_a_idx_i) >= GPR_COUNT && 32'(rd_a_idx_i) < SB;
  assign wr_unmapped = 32'(wr_idx_i) >= GPR_COUNT && 32'(wr_idx_i) < SB;

  // R10
  ldst_range_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_class_i == 2'd1 && 32'(wr_idx_i) >= LDST_COUNT) |=> illegal_o);

  // R12
  idle_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !illegal_o);

  // R3
  unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_unmapped |-> rd_a_data_o == '0);

  // R3
  unmapped_write_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_class_i == 2'd0 && wr_unmapped) |=>
      (!illegal_o && $stable(acc_o) && $stable(mptr_o) && $stable(sp_o) && $stable(pc_o)));

  // R4
  pc_read_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(rd_a_idx_i) == NUM_IDX - 1) |-> rd_a_data_o == pc_o + DW'(PC_READ_OFFSET));

  // R7
  acc_nibble_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && 32'(wr_idx_i) == SB && wr_mode_i == 3'd2) |=>
      acc_o[DW-5:0] == $past(acc_o[DW-5:0]));

  // R10
  stack_class_sp_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_class_i == 2'd2 && 32'(wr_idx_i) == SB + 2) |=> $stable(sp_o));
endmodule

bind regf_core regf_core_chk #(
  .DW(DW), .GPR_COUNT(GPR_COUNT), .NUM_IDX(NUM_IDX), .LDST_COUNT(LDST_COUNT),
  .PC_READ_OFFSET(PC_READ_OFFSET)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
  .wr_mode_i(wr_mode_i), .wr_class_i(wr_class_i), .rd_a_idx_i(rd_a_idx_i),
  .rd_a_data_o(rd_a_data_o), .illegal_o(illegal_o), .acc_o(acc_o), .mptr_o(mptr_o),
  .sp_o(sp_o), .pc_o(pc_o)
);

// File: tb/regf_core_test.sv
`timescale 1ns/1ps
module regf_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [15:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_mode = '0;
  logic [1:0]  wr_class = '0;
  logic        illegal;
  logic [15:0] acc, mptr, sp, pc;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  regf_core uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_a_idx_i(rd_a_idx), .rd_a_data_o(rd_a_data),
    .rd_b_idx_i(rd_b_idx), .rd_b_data_o(rd_b_data), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_mode_i(wr_mode), .wr_class_i(wr_class), .wr_data_i(wr_data), .illegal_o(illegal),
    .acc_o(acc), .mptr_o(mptr), .sp_o(sp), .pc_o(pc)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {class, idx, mode, data, expected readback, expected strobe}
  localparam int NV = 21;
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 6'd5,  3'd0, 16'h1234, 16'h1234, 1'b0},  // R5
    {2'd0, 6'd5,  3'd1, 16'h00AB, 16'hAB34, 1'b0},  // R6
    {2'd0, 6'd5,  3'd2, 16'h0007, 16'h7B34, 1'b0},  // R7
    {2'd0, 6'd6,  3'd3, 16'h0080, 16'hFF80, 1'b0},  // R8
    {2'd0, 6'd6,  3'd3, 16'hFF7F, 16'h007F, 1'b0},  // R8
    {2'd0, 6'd60, 3'd4, 16'h0800, 16'hF800, 1'b0},  // R8
    {2'd0, 6'd60, 3'd2, 16'h0003, 16'h3800, 1'b0},  // R7
    {2'd0, 6'd61, 3'd5, 16'hFFFF, 16'h0FFF, 1'b0},  // R8
    {2'd0, 6'd61, 3'd2, 16'h000A, 16'hAFFF, 1'b0},  // R7
    {2'd0, 6'd7,  3'd0, 16'hFFFF, 16'hFFFF, 1'b0},  // R5
    {2'd2, 6'd7,  3'd6, 16'h5A5A, 16'h0000, 1'b0},  // R9
    {2'd2, 6'd7,  3'd7, 16'h5A5A, 16'hFFFF, 1'b0},  // R9
    {2'd1, 6'd15, 3'd0, 16'h5555, 16'h5555, 1'b0},  // R10
    {2'd1, 6'd16, 3'd0, 16'h1111, 16'h0000, 1'b1},  // R10
    {2'd2, 6'd31, 3'd0, 16'h2222, 16'h2222, 1'b0},  // R10
    {2'd2, 6'd62, 3'd0, 16'h3333, 16'h0000, 1'b1},  // R10
    {2'd3, 6'd62, 3'd0, 16'h0100, 16'h0100, 1'b0},  // R10
    {2'd3, 6'd3,  3'd0, 16'h9999, 16'h0000, 1'b1},  // R10
    {2'd0, 6'd40, 3'd0, 16'hBEEF, 16'h0000, 1'b0},  // R3
    {2'd0, 6'd63, 3'd0, 16'hFFFE, 16'h0002, 1'b0},  // R4
    {2'd0, 6'd0,  3'd0, 16'hC0DE, 16'hC0DE, 1'b0}   // R2
  };

  task automatic do_write(input logic [1:0] c, input logic [5:0] i, input logic [2:0] m,
                          input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_class = c; wr_idx = i; wr_mode = m; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: everything zero after reset
    for (int i = 0; i < 64; i++) begin
      rd_a_idx = 6'(i); #1;
      check(i == 63 ? "R1/R4 pc read after reset" : "R1 reset read", rd_a_data,
            i == 63 ? 16'h0004 : 16'h0000);
    end
    check("R1 acc reset", acc, 16'h0); check("R1 sp reset", sp, 16'h0);
    check("R1 strobe reset", {15'd0, illegal}, 16'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      do_write(VEC[v][43:42], VEC[v][41:36], VEC[v][35:33], VEC[v][32:17]);
      rd_a_idx = VEC[v][41:36]; #1;
      check($sformatf("R2-R10 vector %0d data", v), rd_a_data, VEC[v][16:1]);
      check($sformatf("R10 vector %0d strobe", v), {15'd0, illegal}, {15'd0, VEC[v][0]});
    end

    // R2: dedicated outputs, port B
    check("R2 acc_o", acc, 16'h3800);
    check("R2 mptr_o", mptr, 16'hAFFF);
    check("R2 sp_o", sp, 16'h0100);
    check("R4 pc_o raw", pc, 16'hFFFE);
    rd_b_idx = 6'd63; #1; check("R4 port b pc+4", rd_b_data, 16'h0002);
    rd_b_idx = 6'd5;  #1; check("R2 port b r5", rd_b_data, 16'h7B34);
    rd_b_idx = 6'd16; #1; check("R10 r16 untouched", rd_b_data, 16'h0000);
    rd_b_idx = 6'd3;  #1; check("R10 r3 untouched", rd_b_data, 16'h0000);

    // R10: strobe lasts one cycle
    @(negedge clk); wr_en = 1'b1; wr_class = 2'd1; wr_idx = 6'd20; wr_data = 16'h7777; wr_mode = 3'd0;
    @(negedge clk); wr_en = 1'b0;
    check("R10 strobe raised", {15'd0, illegal}, 16'h1);
    @(negedge clk);
    check("R10 strobe one cycle", {15'd0, illegal}, 16'h0);

    // R12: disabled write with illegal class/index
    @(negedge clk); wr_en = 1'b0; wr_class = 2'd1; wr_idx = 6'd20;
    @(negedge clk);
    check("R12 no strobe when idle", {15'd0, illegal}, 16'h0);
    rd_a_idx = 6'd20; #1; check("R12 no write when idle", rd_a_data, 16'h0000);

    // R3: unmapped top edge
    do_write(2'd0, 6'd59, 3'd0, 16'h4321);
    rd_a_idx = 6'd59; #1; check("R3 idx 59 reads zero", rd_a_data, 16'h0000);
    check("R3 no strobe", {15'd0, illegal}, 16'h0);
    check("R3 acc unchanged", acc, 16'h3800);

    // R11: read-during-write
    @(negedge clk);
    wr_en = 1'b1; wr_class = 2'd0; wr_idx = 6'd0; wr_mode = 3'd0; wr_data = 16'h1111;
    rd_a_idx = 6'd0; #1;
    check("R11 old value same cycle", rd_a_data, 16'hC0DE);
    @(negedge clk); wr_en = 1'b0; #1;
    check("R11 new value next cycle", rd_a_data, 16'h1111);

    // R9: step on accumulator wraps downward from zero via word load
    do_write(2'd0, 6'd60, 3'd0, 16'h0000);
    do_write(2'd0, 6'd60, 3'd7, 16'h0000);
    check("R9 acc dec wrap", acc, 16'hFFFF);

    // R1: asynchronous reset mid-run
    @(negedge clk); #2 rst_n = 1'b0; #1;
    check("R1 async clear acc", acc, 16'h0);
    rd_a_idx = 6'd5; #1; check("R1 async clear r5", rd_a_data, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule